// File: doc/BRIEF.md
# Scanline Dewake Trigger

This block decides when a display pipe should raise its power-wake request ahead of vertical blank. When it is armed, it captures a target scanline. The target is the start line of vertical blank minus the memory latency, already expressed in lines, and it is clamped at zero. In interlaced timing the blank start line is first halved, rounding up. From then on the wake output is high while the live scanline sits between the target and the start of blank. This window repeats on every frame until the block is cleared.

Arming can happen late, when the live scanline is already at the target or a few lines before it. In that case the block sets a forced wake on the same edge, because the window might be missed otherwise. The forced wake is sticky. It holds the output high through blank and through any later arm, and only the clear strobe removes it.

A run that does not wait for blank skips the wake logic. It arms with the wait flag low, and the block then reports a target of -1 and disarms its window.

Top module: `dewake_trigger`

## Requirements
- R1: After reset, `wake` is 0 and `tgt_line` reads -1.
- R2: In progressive mode (`interlaced`=0), an arm with `arm_wait`=1 sets `tgt_line` to `vbl_start - lat_lines` on the next cycle.
- R3: When `lat_lines` exceeds the effective blank start, the captured target is 0. `tgt_line` is never below -1.
- R4: With `interlaced`=1, the effective blank start is ceil(`vbl_start`/2), and it is used both for the target and for the end of the window.
- R5: An arm with `arm_wait`=0 sets `tgt_line` to -1 and disarms the window. It does not change a forced wake that is already set.
- R6: On an arm with `arm_wait`=1, a forced wake is set when d = target - `cur_line` (sampled at that edge) satisfies 0 <= d < 5. A d of 5 or of -1 sets no forced wake.
- R7: A forced wake keeps `wake` at 1 for every value of `cur_line` until a clear.
- R8: When armed and not forced, `wake` is 1 exactly when target <= `cur_line` < effective blank start. It follows `cur_line` combinationally.
- R9: `clr` removes the forced wake, disarms the window and sets `tgt_line` to -1 from the next cycle.
- R10: When `clr` and `arm` are high on the same edge, `clr` wins and the arm has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vbl_start | input | LW | First line of vertical blank |
| interlaced | input | 1 | Halve the blank start, rounding up |
| lat_lines | input | LW | Wake latency in lines |
| cur_line | input | LW | Live scanline counter |
| arm | input | 1 | Arm strobe, one cycle |
| arm_wait | input | 1 | 1: run waits for blank and uses dewake; 0: skip |
| clr | input | 1 | Clear strobe for forced wake and arming |
| wake | output | 1 | Power-wake request |
| tgt_line | output | LW+1 (signed) | Captured target, -1 when not armed |

## Verification
The assertions assume that `vbl_start`, `lat_lines` and `interlaced` hold steady on the arm edge. They also assume that `cur_line` stays below 2^LW and is treated as an unsigned count. The stimulus changes inputs only at the falling edge and keeps every line value well inside the 13-bit range. Scanline values are placed directly rather than counted up, so that each boundary of the force window and the blank window can be hit exactly.

// File: rtl/dewake_trigger.sv
module dewake_trigger #(
  parameter int LW        = 13,
  parameter int FORCE_WIN = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LW-1:0]        vbl_start,
  input  logic                 interlaced,
  input  logic [LW-1:0]        lat_lines,
  input  logic [LW-1:0]        cur_line,
  input  logic                 arm,
  input  logic                 arm_wait,
  input  logic                 clr,
  output logic                 wake,
  output logic signed [LW:0]   tgt_line
);
  localparam int DW = LW + 2;

  logic [LW:0]           vbl_p1;
  logic [LW-1:0]         vbs_eff, vbs_q, tgt_new;
  logic signed [DW-1:0]  raw, diff;
  logic                  armed_q, force_q, force_hit, in_window;

  assign vbl_p1    = {1'b0, vbl_start} + {{LW{1'b0}}, 1'b1};
  assign vbs_eff   = interlaced ? vbl_p1[LW:1] : vbl_start;
  assign raw       = $signed({2'b00, vbs_eff}) - $signed({2'b00, lat_lines});
  assign tgt_new   = raw[DW-1] ? '0 : raw[LW-1:0];
  assign diff      = $signed({2'b00, tgt_new}) - $signed({2'b00, cur_line});
  assign force_hit = !diff[DW-1] && (diff < $signed(DW'(FORCE_WIN)));

  assign in_window = armed_q && (cur_line >= tgt_line[LW-1:0]) && (cur_line < vbs_q);
  assign wake      = force_q | in_window;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      force_q  <= 1'b0;
      tgt_line <= '1;
      vbs_q    <= '0;
    end else if (clr) begin
      armed_q  <= 1'b0;
      force_q  <= 1'b0;
      tgt_line <= '1;
    end else if (arm) begin
      if (arm_wait) begin
        armed_q  <= 1'b1;
        tgt_line <= $signed({1'b0, tgt_new});
        vbs_q    <= vbs_eff;
        if (force_hit) force_q <= 1'b1;
      end else begin
        armed_q  <= 1'b0;
        tgt_line <= '1;
      end
    end
  end
endmodule

module dewake_trigger_chk #(parameter int LW = 13) (
  input logic                clk,
  input logic                rst_n,
  input logic                arm,
  input logic                arm_wait,
  input logic                clr,
  input logic                wake,
  input logic signed [LW:0]  tgt_line,
  input logic                force_q
);
  assert_tgt_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_line >= -1);

  assert_skip_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !arm_wait && !clr) |=> (tgt_line == -1));

  assert_force_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (force_q && !clr) |=> (force_q && wake));

  assert_window_needs_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !force_q) |-> (tgt_line >= 0));

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!wake && tgt_line == -1 && !force_q));
endmodule

bind dewake_trigger dewake_trigger_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .arm_wait(arm_wait), .clr(clr),
  .wake(wake), .tgt_line(tgt_line), .force_q(force_q)
);

// File: tb/dewake_trigger_bench.sv
module dewake_trigger_bench;
  localparam int LW = 13;

  logic clk = 0, rst_n = 0;
  logic [LW-1:0] vbl_start = 0, lat_lines = 0, cur_line = 0;
  logic interlaced = 0, arm = 0, arm_wait = 0, clr = 0;
  logic wake;
  logic signed [LW:0] tgt_line;

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  int m_tgt = -1, m_vbs = 0;
  bit m_armed = 0, m_force = 0;

  always #5 clk = ~clk;

  dewake_trigger #(.LW(LW)) u_dewake_trigger (
    .clk(clk), .rst_n(rst_n), .vbl_start(vbl_start), .interlaced(interlaced),
    .lat_lines(lat_lines), .cur_line(cur_line), .arm(arm), .arm_wait(arm_wait),
    .clr(clr), .wake(wake), .tgt_line(tgt_line)
  );

  always @(posedge clk) begin
    int v, t, d;
    if (!rst_n) begin
      m_tgt = -1; m_armed = 0; m_force = 0; m_vbs = 0;
    end else if (clr) begin
      m_tgt = -1; m_armed = 0; m_force = 0;
    end else if (arm) begin
      if (arm_wait) begin
        v = interlaced ? (int'(vbl_start) + 1) / 2 : int'(vbl_start);
        t = v - int'(lat_lines);
        if (t < 0) t = 0;
        d = t - int'(cur_line);
        if (d >= 0 && d < 5) m_force = 1;
        m_tgt = t; m_vbs = v; m_armed = 1;
      end else begin
        m_tgt = -1; m_armed = 0;
      end
    end
  end

  task automatic compare();
    bit ew;
    int c;
    c  = int'(cur_line);
    ew = m_force || (m_armed && c >= m_tgt && c < m_vbs);
    n_cmp++;
    if (wake !== ew) begin
      n_bad++;
      $display("FAIL %s wake cur=%0d actual=%b expected=%b", tag, c, wake, ew);
    end
    n_cmp++;
    if (int'(tgt_line) != m_tgt) begin
      n_bad++;
      $display("FAIL %s tgt_line actual=%0d expected=%0d", tag, int'(tgt_line), m_tgt);
    end
  endtask

  always @(negedge clk) if (rst_n) compare();

  task automatic cyc(input int cur, input bit a = 0, input bit w = 1, input bit c = 0);
    cur_line = LW'(cur); arm = a; arm_wait = w; clr = c;
    @(negedge clk);
    arm = 0; clr = 0;
  endtask

  task automatic setmode(input int vbl, input int lat, input bit il);
    vbl_start = LW'(vbl); lat_lines = LW'(lat); interlaced = il;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; cyc(0); cyc(500);

    tag = "R2"; setmode(1000, 100, 0); cyc(10, 1);
    tag = "R8"; cyc(899); cyc(900); cyc(950); cyc(999); cyc(1000); cyc(1200); cyc(5);
    tag = "R9"; cyc(950, 0, 1, 1); cyc(950);

    tag = "R3"; setmode(1000, 1200, 0); cyc(500, 1); cyc(0); cyc(999); cyc(1000);
    cyc(0, 0, 1, 1);
    tag = "R4"; setmode(1001, 1, 1); cyc(20, 1); cyc(499); cyc(500); cyc(501);
    setmode(1000, 1, 1); cyc(20, 1); cyc(498); cyc(499); cyc(500);
    cyc(0, 0, 1, 1);

    tag = "R6"; setmode(1000, 100, 0);
    cyc(900, 1); cyc(1100); cyc(0, 0, 1, 1);
    cyc(896, 1); cyc(1100); cyc(0, 0, 1, 1);
    cyc(895, 1); cyc(1100); cyc(0, 0, 1, 1);
    cyc(901, 1); cyc(1100); cyc(0, 0, 1, 1);

    tag = "R7"; cyc(898, 1);
    for (int i = 0; i < 8; i++) cyc(i * 300);
    tag = "R5"; cyc(10, 1, 0); cyc(10); cyc(950); cyc(1100);
    tag = "R9"; cyc(10, 0, 1, 1); cyc(10); cyc(950);
    tag = "R5"; cyc(0, 1, 0); cyc(900); cyc(950);

    tag = "R10"; cyc(898, 1, 1, 1); cyc(898); cyc(950);
    cyc(0, 0, 1, 1);
    tag = "R1"; rst_n = 0; cyc(950, 1); rst_n = 1; cyc(950); cyc(950);

    finish_run();
  end
endmodule